// File: doc/BRIEF.md
# Eight-bit timer/counter with shared prescaler

This block is an 8-bit up-counter for a small microcontroller core. On each clock it may advance once. The count comes either from the core's own instruction cycle, where one clock is one instruction cycle, or from edges on an external input pin. The external pin is first brought into the clock domain through a chain of flip-flops. The active edge of the pin can be chosen.

A prescaler counter can sit in the count path and divide the selected source by a power of two. When software gives the prescaler to the watchdog instead, the timer runs undivided. The prescaler then counts every clock and emits a one-cycle watchdog tick. The prescaler's count is never visible on the register bus.

When the counter wraps it sets a sticky overflow flag, and an enable bit masks the interrupt output. A bus write to the counter blocks counting for the two cycles that follow and restarts the prescaler phase. A sleep input stops counting.

Top module: `tmr8_presc`

## Requirements
- R1: While reset is held, the counter reads 0x00, the control register reads 0x04, the interrupt register reads 0x00, and irq and wdt_tick are both low.
- R2: The register map is as follows. Address 0 is the counter, which can be read and written. Address 1 is the control register, with bit 0 as source select (1 = external pin), bit 1 as edge select (1 = falling), bit 2 as prescaler assignment (1 = watchdog) and bits 5:3 as the ratio field. Bits 7:6 of the control register read 0. Address 2 holds the flag in bit 0 and the enable in bit 1. Address 3 reads 0x00, so the prescaler count is never readable.
- R3: With the internal source selected and the prescaler assigned to the watchdog, the counter advances by one on every clock edge.
- R4: After the clock edge that writes the counter, the two following edges do not advance it. The third following edge does. Such a write wins over an increment in the same cycle.
- R5: With the external source selected and edge select at 0, a rising pin edge that is set up before clock edge a advances the counter at edge a+2, not earlier. A falling pin edge is ignored.
- R6: With edge select at 1, only falling pin edges advance the counter, with the same two-edge latency as R5.
- R7: With assignment 0 and ratio field r, the counter advances once every 2^(r+1) source pulses. After a counter write at edge k, with the internal source, the first increment comes at edge k+2+2^(r+1). For example, with r=1 the increments come at k+6 and k+10, and with r=7 the first comes at k+258.
- R8: With assignment 1, wdt_tick is high for one cycle in every 2^(r+1) clocks. After a counter write at edge k, it is first high after edge k+2^(r+1)-1. With assignment 0, wdt_tick stays low.
- R9: A wrap from 0xFF to 0x00 sets the flag. irq is high exactly when both the flag and the enable are set.
- R10: The flag stays set until a bus write puts a 0 in bit 0 of address 2. If such a write falls on the same edge as a wrap, the flag ends up set.
- R11: While sleep is high, the counter does not advance. Counting resumes on the first edge after sleep falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one instruction cycle |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register (combinational) |
| ext_pin | input | 1 | External count input, asynchronous |
| sleep | input | 1 | Stops counting while high |
| irq | output | 1 | Interrupt request |
| wdt_tick | output | 1 | Prescaled tick for the watchdog |

## Verification
Two pairs of functions can fall on the same edge. The first pair is the 0xFF-to-0x00 wrap and a software write that clears the flag. The second pair is an increment and a bus write to the counter. For the first pair, the bench loads 0xFE, counts the edges through the inhibit window and the step to 0xFF, and then lands the clearing write on the exact edge of the wrap. It judges the result by the flag and irq read back afterwards, which must both show the overflow. For the second pair, the bench writes while the counter is running every cycle, and the read-back value must be the written one with no increment added.

// File: rtl/tmr8_presc.sv
module tmr8_presc #(
  parameter int DW = 8,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          ext_pin,
  input  logic          sleep,
  output logic          irq,
  output logic          wdt_tick
);
  localparam int PW = 1 << RW;
  localparam int CW = 3 + RW;

  logic [DW-1:0] cnt;
  logic          src_ext, edge_fall, psa;
  logic [RW-1:0] ratio;
  logic          flag, ien;
  logic [1:0]    inh;
  logic [PW-1:0] psc;
  logic [2:0]    sy;

  wire wr_cnt  = wr_en && addr == 2'd0;
  wire wr_ctrl = wr_en && addr == 2'd1;
  wire wr_irq  = wr_en && addr == 2'd2;

  logic [PW:0]   mask_w;
  logic [PW-1:0] mask;
  assign mask_w = ((PW+1)'(1) << (32'(ratio) + 1)) - (PW+1)'(1);
  assign mask   = mask_w[PW-1:0];
  wire psc_full = (psc & mask) == mask;

  wire ext_hit   = edge_fall ? (sy[2] & ~sy[1]) : (sy[1] & ~sy[2]);
  wire src_pulse = src_ext ? ext_hit : 1'b1;
  wire gated     = src_pulse & ~sleep & (inh == 2'd0);
  wire psc_step  = psa ? 1'b1 : gated;
  wire tmr_step  = psa ? gated : (gated & psc_full);
  wire ovf       = tmr_step & (cnt == '1) & ~wr_cnt;

  assign wdt_tick = psa & psc_full;
  assign irq      = flag & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], ext_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_ext <= 1'b0; edge_fall <= 1'b0; psa <= 1'b1; ratio <= '0;
    end else if (wr_ctrl) begin
      src_ext   <= wr_data[0];
      edge_fall <= wr_data[1];
      psa       <= wr_data[2];
      ratio     <= wr_data[3 +: RW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; inh <= '0; psc <= '0;
    end else begin
      if (wr_cnt)        cnt <= wr_data;
      else if (tmr_step) cnt <= cnt + 1'b1;
      if (wr_cnt)              inh <= 2'd2;
      else if (inh != 2'd0)    inh <= inh - 2'd1;
      if (wr_cnt)        psc <= '0;
      else if (psc_step) psc <= psc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0; ien <= 1'b0;
    end else begin
      if (ovf)         flag <= 1'b1;
      else if (wr_irq) flag <= wr_data[0];
      if (wr_irq)      ien  <= wr_data[1];
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      2'd0: rd_data = cnt;
      2'd1: rd_data[CW-1:0] = {ratio, psa, edge_fall, src_ext};
      2'd2: rd_data[1:0] = {ien, flag};
      default: rd_data = '0;
    endcase
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> (cnt == $past(cnt) || cnt == $past(cnt) + DW'(1)));

  p_inhibit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inh != 2'd0 && !wr_cnt) |=> cnt == $past(cnt));

  p_sleep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !wr_cnt) |=> cnt == $past(cnt));

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '1 && tmr_step && !wr_cnt) |=> (flag && cnt == '0));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wr_irq) |=> flag);

  p_wdt_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_tick && !wr_en) |=> !wdt_tick);
endmodule

// File: tb/tmr8_presc_test.sv
module tmr8_presc_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic wr_en = 1'b0, ext_pin = 1'b0, sleep = 1'b0;
  logic [7:0] wr_data = 8'h00, rd_data;
  logic irq, wdt_tick;
  int total = 0, bad = 0;
  bit done = 1'b0;

  tmr8_presc uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .ext_pin(ext_pin), .sleep(sleep),
    .irq(irq), .wdt_tick(wdt_tick));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rd_data;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 counter", v, 8'h00);
    rd(2'd1, v); chk("R1 control", v, 8'h04);
    rd(2'd2, v); chk("R1 irq reg", v, 8'h00);
    chk("R1 irq pin", {7'd0, irq}, 8'h00);
    chk("R1 wdt_tick", {7'd0, wdt_tick}, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    bus_write(2'd1, 8'hFF);
    rd(2'd1, v); chk("R2 control readback", v, 8'h3F);
    bus_write(2'd1, 8'h04);
    rd(2'd3, v); chk("R2 address 3", v, 8'h00);
  endtask

  task automatic t_inhibit;
    logic [7:0] v;
    bus_write(2'd0, 8'h10);
    rd(2'd0, v); chk("R4 write wins", v, 8'h10);
    step(1); rd(2'd0, v); chk("R4 inhibit edge 1", v, 8'h10);
    step(1); rd(2'd0, v); chk("R4 inhibit edge 2", v, 8'h10);
    step(1); rd(2'd0, v); chk("R4 resume edge 3", v, 8'h11);
    step(1); rd(2'd0, v); chk("R3 one per clock", v, 8'h12);
    step(5); rd(2'd0, v); chk("R3 run", v, 8'h17);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    bus_write(2'd2, 8'h00);
    bus_write(2'd0, 8'hFE);
    step(3); rd(2'd0, v); chk("R9 at FF", v, 8'hFF);
    rd(2'd2, v); chk("R9 no flag yet", v, 8'h00);
    step(1); rd(2'd0, v); chk("R9 wrapped", v, 8'h00);
    rd(2'd2, v); chk("R9 flag set", v, 8'h01);
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    bus_write(2'd2, 8'h03);
    chk("R9 irq enabled", {7'd0, irq}, 8'h01);
    step(10); rd(2'd2, v); chk("R10 flag sticky", v, 8'h03);
    bus_write(2'd2, 8'h02);
    rd(2'd2, v); chk("R10 flag cleared", v, 8'h02);
    chk("R10 irq dropped", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    bus_write(2'd0, 8'hFE);
    step(3); rd(2'd0, v); chk("R10 pre-wrap", v, 8'hFF);
    bus_write(2'd2, 8'h02);
    rd(2'd2, v); chk("R10 overflow beats clear", v, 8'h03);
    chk("R10 irq after collide", {7'd0, irq}, 8'h01);
    bus_write(2'd2, 8'h00);
  endtask

  task automatic t_prescale;
    logic [7:0] v;
    bus_write(2'd1, 8'h08);
    bus_write(2'd0, 8'h20);
    step(5); rd(2'd0, v); chk("R7 1:4 before", v, 8'h20);
    chk("R8 tick low when timer owns", {7'd0, wdt_tick}, 8'h00);
    step(1); rd(2'd0, v); chk("R7 1:4 first", v, 8'h21);
    step(3); rd(2'd0, v); chk("R7 1:4 hold", v, 8'h21);
    step(1); rd(2'd0, v); chk("R7 1:4 second", v, 8'h22);
    bus_write(2'd1, 8'h38);
    bus_write(2'd0, 8'h50);
    step(257); rd(2'd0, v); chk("R7 1:256 before", v, 8'h50);
    step(1); rd(2'd0, v); chk("R7 1:256 first", v, 8'h51);
  endtask

  task automatic t_wdt;
    bus_write(2'd1, 8'h04);
    bus_write(2'd0, 8'h00);
    chk("R8 1:2 phase 0", {7'd0, wdt_tick}, 8'h00);
    step(1); chk("R8 1:2 phase 1", {7'd0, wdt_tick}, 8'h01);
    step(1); chk("R8 1:2 phase 2", {7'd0, wdt_tick}, 8'h00);
    bus_write(2'd1, 8'h14);
    bus_write(2'd0, 8'h00);
    step(6); chk("R8 1:8 before", {7'd0, wdt_tick}, 8'h00);
    step(1); chk("R8 1:8 tick", {7'd0, wdt_tick}, 8'h01);
    step(1); chk("R8 1:8 after", {7'd0, wdt_tick}, 8'h00);
    bus_write(2'd1, 8'h04);
  endtask

  task automatic t_external;
    logic [7:0] v;
    bus_write(2'd1, 8'h05);
    bus_write(2'd0, 8'h40);
    step(3);
    ext_pin = 1'b1;
    step(1); rd(2'd0, v); chk("R5 sync edge a", v, 8'h40);
    step(1); rd(2'd0, v); chk("R5 sync edge a+1", v, 8'h40);
    step(1); rd(2'd0, v); chk("R5 rising counted", v, 8'h41);
    step(4); rd(2'd0, v); chk("R5 level no count", v, 8'h41);
    ext_pin = 1'b0;
    step(4); rd(2'd0, v); chk("R5 falling ignored", v, 8'h41);
    bus_write(2'd1, 8'h07);
    ext_pin = 1'b1;
    step(4); rd(2'd0, v); chk("R6 rising ignored", v, 8'h41);
    ext_pin = 1'b0;
    step(2); rd(2'd0, v); chk("R6 sync", v, 8'h41);
    step(1); rd(2'd0, v); chk("R6 falling counted", v, 8'h42);
    bus_write(2'd1, 8'h04);
  endtask

  task automatic t_sleep;
    logic [7:0] v;
    bus_write(2'd0, 8'h80);
    step(3);
    sleep = 1'b1;
    rd(2'd0, v); chk("R11 entry", v, 8'h81);
    step(5); rd(2'd0, v); chk("R11 frozen", v, 8'h81);
    sleep = 1'b0;
    step(1); rd(2'd0, v); chk("R11 resume", v, 8'h82);
  endtask

  initial begin
    step(2);
    t_reset;
    rst_n = 1'b1;
    step(1);
    t_regs;
    t_inhibit;
    t_overflow;
    t_collide;
    t_prescale;
    t_wdt;
    t_external;
    t_sleep;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule